// File: doc/BRIEF.md
# Unsigned Multiply Group Decoder

This block classifies one already-split instruction record per clock and decides whether it is a legal unsigned multiply. The record arrives as separate fields: a primary opcode byte, the ModRM byte, four prefix flags (REX seen, REX.W, operand-size override, LOCK) and a bit that says whether the core runs in 64-bit mode. The block then reports four things:

- whether the record is a legal unsigned multiply;
- the operand width that the execution stage must use;
- where the explicit, read-only source operand lives;
- whether the record must raise an invalid-opcode fault.

The other multiply operand and the destination are implied, so they need no output.

A downstream execution stage takes the width code and source selector together with the legal strobe. It treats the fault flag as a request to raise an invalid-opcode exception in place of executing. Records that do not belong to the multiply group leave both strobes low, so other decoders can claim them. All outputs are registered. A result appears one clock after the record is presented with its input strobe.

Top module: `umul_decoder`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `out_valid`, `out_fault`, `out_size`, `out_src_mem` and `out_src_rm` are all zero.
- R2: A record with opcode 0xF6 and ModRM bits [5:3] equal to 4, no LOCK, and either no REX or REX in 64-bit mode, yields `out_valid`=1, `out_fault`=0 and `out_size`=0 (the 8-bit code).
- R3: Opcode 0xF7 with ModRM bits [5:3] equal to 4, in 64-bit mode, with REX and REX.W both set and no LOCK, yields `out_valid`=1 and `out_size`=3 (the 64-bit code).
- R4: For a legal 0xF7 multiply without an effective REX.W, the operand-size override selects `out_size`=1 (the 16-bit code). REX.W in 64-bit mode takes priority over the override and still gives code 3.
- R5: A legal 0xF7 multiply with neither REX.W nor the override gives `out_size`=2 (the 32-bit code), in 64-bit mode and outside it.
- R6: Outside 64-bit mode, a multiply record (0xF6 or 0xF7 with ModRM bits [5:3] equal to 4) that carries the REX flag yields `out_fault`=1 and `out_valid`=0.
- R7: A multiply record with LOCK set yields `out_fault`=1 and `out_valid`=0, in any mode.
- R8: Any other opcode, or 0xF6/0xF7 with ModRM bits [5:3] other than 4, yields `out_valid`=0 and `out_fault`=0, even with LOCK or REX set.
- R9: For every accepted record, `out_src_mem` is 1 exactly when ModRM bits [7:6] are not 3, and `out_src_rm` equals ModRM bits [2:0].
- R10: Outputs change only on the clock edge that samples `in_valid`=1. After an edge with `in_valid`=0, `out_valid` and `out_fault` are 0, and `out_size`, `out_src_mem` and `out_src_rm` keep their previous values.
- R11: `out_valid` and `out_fault` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Record present this cycle |
| long_mode | input | 1 | Core is in 64-bit mode |
| pfx_rex | input | 1 | A REX prefix was seen |
| pfx_rexw | input | 1 | REX.W bit (meaningful only with `pfx_rex`) |
| pfx_opsz | input | 1 | Operand-size override prefix seen |
| pfx_lock | input | 1 | LOCK prefix seen |
| opcode | input | 8 | Primary opcode byte |
| modrm | input | 8 | ModRM byte |
| out_valid | output | 1 | Legal unsigned multiply decoded |
| out_fault | output | 1 | Invalid-opcode fault requested |
| out_size | output | 2 | Width code: 0=8, 1=16, 2=32, 3=64 bits |
| out_src_mem | output | 1 | Source operand is in memory |
| out_src_rm | output | 3 | ModRM r/m field of the source |

## Verification
Two decisions can be made on the same record, and the bench provokes both. The first is width selection when REX.W and the operand-size override arrive together. The bench sends this pair in 64-bit mode and expects the 64-bit code, then sends it outside 64-bit mode and expects a fault instead. The second is the fault path when LOCK and an illegal REX come together, and when LOCK sits on an otherwise legal 64-bit form. The bench judges each of these by the fault flag alone, with the legal strobe low. A separate check sends LOCK on a non-multiply record, which must stay silent.

// File: rtl/umul_pkg.sv
package umul_pkg;

  localparam int unsigned OPC_W = 8;
  localparam int unsigned SZ_W  = 2;

  typedef enum logic [SZ_W-1:0] {
    SZ_B8  = 2'd0,
    SZ_B16 = 2'd1,
    SZ_B32 = 2'd2,
    SZ_B64 = 2'd3
  } umul_size_e;

  // Width choice: byte form fixed, else REX.W beats override beats default.
  function automatic umul_size_e pick_size(input logic is_byte,
                                           input logic wide64,
                                           input logic ovr16);
    if (is_byte)      return SZ_B8;
    else if (wide64)  return SZ_B64;
    else if (ovr16)   return SZ_B16;
    else              return SZ_B32;
  endfunction

  function automatic logic [1:0] modrm_mod(input logic [7:0] m);
    return m[7:6];
  endfunction

  function automatic logic [2:0] modrm_reg(input logic [7:0] m);
    return m[5:3];
  endfunction

  function automatic logic [2:0] modrm_rm(input logic [7:0] m);
    return m[2:0];
  endfunction

endpackage

// File: rtl/umul_match.sv
module umul_match #(
  parameter int unsigned          OPC_W    = 8,
  parameter logic [OPC_W-1:0]     OPC_BYTE = 8'hF6,
  parameter logic [OPC_W-1:0]     OPC_WIDE = 8'hF7,
  parameter logic [2:0]           GRP_SEL  = 3'd4
) (
  input  logic [OPC_W-1:0] opcode,
  input  logic [7:0]       modrm,
  output logic             hit,
  output logic             is_byte
);
  import umul_pkg::*;

  logic sel_ok;
  logic op_byte;
  logic op_wide;

  always_comb begin
    sel_ok  = (modrm_reg(modrm) == GRP_SEL);
    op_byte = (opcode == OPC_BYTE);
    op_wide = (opcode == OPC_WIDE);
    hit     = sel_ok && (op_byte || op_wide);
    is_byte = op_byte;
  end

endmodule

// File: rtl/umul_size_sel.sv
module umul_size_sel
  import umul_pkg::*;
(
  input  logic       is_byte,
  input  logic       wide64,
  input  logic       ovr16,
  output umul_size_e size
);
  always_comb size = pick_size(is_byte, wide64, ovr16);
endmodule

// File: rtl/umul_fault_chk.sv
module umul_fault_chk (
  input  logic hit,
  input  logic lock,
  input  logic rex,
  input  logic long_mode,
  output logic lock_bad,
  output logic rex_bad,
  output logic fault
);
  always_comb begin
    lock_bad = hit && lock;
    rex_bad  = hit && rex && !long_mode;
    fault    = lock_bad || rex_bad;
  end
endmodule

// File: rtl/umul_decoder.sv
module umul_decoder
  import umul_pkg::*;
#(
  parameter int unsigned      OPC_W    = umul_pkg::OPC_W,
  parameter logic [OPC_W-1:0] OPC_BYTE = 8'hF6,
  parameter logic [OPC_W-1:0] OPC_WIDE = 8'hF7,
  parameter logic [2:0]       GRP_SEL  = 3'd4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             long_mode,
  input  logic             pfx_rex,
  input  logic             pfx_rexw,
  input  logic             pfx_opsz,
  input  logic             pfx_lock,
  input  logic [OPC_W-1:0] opcode,
  input  logic [7:0]       modrm,
  output logic             out_valid,
  output logic             out_fault,
  output logic [1:0]       out_size,
  output logic             out_src_mem,
  output logic [2:0]       out_src_rm
);

  localparam logic [1:0] MOD_REG = 2'b11;

  // Named internal events, used by the bound checker.
  logic       hit;
  logic       is_byte;
  logic       wide64;
  logic       lock_bad;
  logic       rex_bad;
  logic       dec_fault;
  logic       dec_ok;
  umul_size_e dec_size;

  assign wide64 = pfx_rex && pfx_rexw && long_mode;

  umul_match #(
    .OPC_W    (OPC_W),
    .OPC_BYTE (OPC_BYTE),
    .OPC_WIDE (OPC_WIDE),
    .GRP_SEL  (GRP_SEL)
  ) u_match (
    .opcode  (opcode),
    .modrm   (modrm),
    .hit     (hit),
    .is_byte (is_byte)
  );

  umul_size_sel u_size (
    .is_byte (is_byte),
    .wide64  (wide64),
    .ovr16   (pfx_opsz),
    .size    (dec_size)
  );

  umul_fault_chk u_fault (
    .hit       (hit),
    .lock      (pfx_lock),
    .rex       (pfx_rex),
    .long_mode (long_mode),
    .lock_bad  (lock_bad),
    .rex_bad   (rex_bad),
    .fault     (dec_fault)
  );

  assign dec_ok = hit && !dec_fault;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_fault   <= 1'b0;
      out_size    <= SZ_B8;
      out_src_mem <= 1'b0;
      out_src_rm  <= 3'd0;
    end else if (in_valid) begin
      out_valid   <= dec_ok;
      out_fault   <= dec_fault;
      out_size    <= dec_size;
      out_src_mem <= (modrm_mod(modrm) != MOD_REG);
      out_src_rm  <= modrm_rm(modrm);
    end else begin
      out_valid   <= 1'b0;
      out_fault   <= 1'b0;
    end
  end

endmodule

// File: rtl/umul_decoder_chk.sv
module umul_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       long_mode,
  input logic       pfx_rex,
  input logic       pfx_rexw,
  input logic       pfx_opsz,
  input logic       pfx_lock,
  input logic [7:0] opcode,
  input logic [7:0] modrm,
  input logic       hit,
  input logic       out_valid,
  input logic       out_fault,
  input logic [1:0] out_size,
  input logic       out_src_mem,
  input logic [2:0] out_src_rm
);

  p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && out_fault));

  p_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && hit && pfx_lock |=> out_fault && !out_valid);

  p_legacy_rex_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && hit && pfx_rex && !long_mode |=> out_fault && !out_valid);

  p_other_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !hit |=> !out_valid && !out_fault);

  p_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && hit && opcode == 8'hF6 && !pfx_lock && !(pfx_rex && !long_mode)
    |=> out_valid && out_size == 2'd0);

  p_wide64_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && hit && opcode == 8'hF7 && long_mode && pfx_rex && pfx_rexw && !pfx_lock
    |=> out_valid && out_size == 2'd3);

  p_ovr16_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && hit && opcode == 8'hF7 && !pfx_lock && !pfx_rex && pfx_opsz
    |=> out_valid && out_size == 2'd1);

  p_dflt32_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && hit && opcode == 8'hF7 && !pfx_lock && !pfx_rex && !pfx_opsz
    |=> out_valid && out_size == 2'd2);

  p_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_src_rm == $past(modrm[2:0])
             && out_src_mem == ($past(modrm[7:6]) != 2'b11));

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && !out_fault && $stable(out_size)
               && $stable(out_src_rm) && $stable(out_src_mem));

  // R4 companion: REX.W wins over the override; pfx_rexw read here.
  p_rexw_prio_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && hit && opcode == 8'hF7 && long_mode && pfx_rex && pfx_rexw
    && pfx_opsz && !pfx_lock |=> out_size == 2'd3);

endmodule

bind umul_decoder umul_decoder_chk u_chk (.*);

// File: tb/umul_decoder_bench.sv
`timescale 1ns/1ps
module umul_decoder_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid;
  logic       long_mode, pfx_rex, pfx_rexw, pfx_opsz, pfx_lock;
  logic [7:0] opcode, modrm;
  logic       out_valid, out_fault, out_src_mem;
  logic [1:0] out_size;
  logic [2:0] out_src_rm;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  umul_decoder u_umul_decoder (
    .clk, .rst_n, .in_valid, .long_mode, .pfx_rex, .pfx_rexw, .pfx_opsz,
    .pfx_lock, .opcode, .modrm, .out_valid, .out_fault, .out_size,
    .out_src_mem, .out_src_rm
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Independent model: returns {valid, fault, size[1:0]}.
  function automatic logic [3:0] model(input logic lm, rex, rw, osz, lk,
                                       input logic [7:0] op, m);
    logic grp;
    logic [1:0] sz;
    grp = (m[5:3] == 3'b100) && (op[7:1] == 7'b1111011);
    if (!grp) return 4'b0000;
    if (lk || (rex && !lm)) return 4'b0100;
    case ({op[0], lm && rex && rw, osz})
      3'b000, 3'b001, 3'b010, 3'b011: sz = 2'd0;
      3'b110, 3'b111:                 sz = 2'd3;
      3'b101:                         sz = 2'd1;
      default:                        sz = 2'd2;
    endcase
    return {2'b10, sz};
  endfunction

  // Drive at a negedge, let one posedge capture, compare at the next negedge.
  task automatic send(input string req, input logic lm, rex, rw, osz, lk,
                      input logic [7:0] op, m);
    logic [3:0] e;
    e = model(lm, rex, rw, osz, lk, op, m);
    long_mode = lm; pfx_rex = rex; pfx_rexw = rw; pfx_opsz = osz;
    pfx_lock = lk; opcode = op; modrm = m; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid"}, int'(out_valid), int'(e[3]));
    check({req, " fault"}, int'(out_fault), int'(e[2]));
    if (e[3]) check({req, " size"}, int'(out_size), int'(e[1:0]));
    check({req, " src_rm"}, int'(out_src_rm), int'(m[2:0]));
    check({req, " src_mem"}, int'(out_src_mem), int'(m[7:6] != 2'b11));
  endtask

  task automatic t_reset_r1();
    rst_n = 1'b0; in_valid = 1'b0; long_mode = 1'b0; pfx_rex = 1'b0;
    pfx_rexw = 1'b0; pfx_opsz = 1'b0; pfx_lock = 1'b0;
    opcode = 8'h00; modrm = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid", int'(out_valid), 0);
    check("R1 fault", int'(out_fault), 0);
    check("R1 size", int'(out_size), 0);
    check("R1 src", int'({out_src_mem, out_src_rm}), 0);
  endtask

  task automatic t_byte_r2();
    send("R2 byte legacy", 0, 0, 0, 0, 0, 8'hF6, 8'hE3);
    send("R2 byte rex long", 1, 1, 0, 0, 0, 8'hF6, 8'h65);
    send("R2 byte with opsz", 1, 0, 0, 1, 0, 8'hF6, 8'hE0);
  endtask

  task automatic t_wide64_r3();
    send("R3 rexw long", 1, 1, 1, 0, 0, 8'hF7, 8'hE1);
    check("R3 size code", int'(out_size), 3);
  endtask

  task automatic t_ovr16_r4();
    send("R4 opsz long", 1, 0, 0, 1, 0, 8'hF7, 8'h27);
    send("R4 opsz legacy", 0, 0, 0, 1, 0, 8'hF7, 8'hE2);
    send("R4 rexw beats opsz", 1, 1, 1, 1, 0, 8'hF7, 8'hA4);
    check("R4 prio code", int'(out_size), 3);
    send("R4 rex no w opsz", 1, 1, 0, 1, 0, 8'hF7, 8'hE6);
  endtask

  task automatic t_dflt32_r5();
    send("R5 default long", 1, 0, 0, 0, 0, 8'hF7, 8'hE5);
    send("R5 default legacy", 0, 0, 0, 0, 0, 8'hF7, 8'h60);
    check("R5 code", int'(out_size), 2);
  endtask

  task automatic t_rex_legacy_r6();
    send("R6 byte rex legacy", 0, 1, 0, 0, 0, 8'hF6, 8'hE3);
    send("R6 rexw legacy", 0, 1, 1, 1, 0, 8'hF7, 8'hE3);
    check("R6 fault seen", int'(out_fault), 1);
  endtask

  task automatic t_lock_r7();
    send("R7 lock byte", 0, 0, 0, 0, 1, 8'hF6, 8'h20);
    send("R7 lock rexw long", 1, 1, 1, 0, 1, 8'hF7, 8'hE4);
    send("R7 lock plus legacy rex", 0, 1, 0, 0, 1, 8'hF7, 8'hE4);
    check("R7 fault seen", int'(out_fault), 1);
  endtask

  task automatic t_other_r8();
    send("R8 reg5 F7", 1, 0, 0, 0, 0, 8'hF7, 8'hE8);
    send("R8 reg6 F6 lock", 0, 0, 0, 0, 1, 8'hF6, 8'hF0);
    send("R8 opcode F5", 1, 1, 1, 0, 0, 8'hF5, 8'hE0);
    send("R8 opcode 77 rex legacy", 0, 1, 0, 0, 1, 8'h77, 8'h20);
  endtask

  task automatic t_src_r9();
    for (int k = 0; k < 4; k++)
      send("R9 src mode", 1, 0, 0, 0, 0, 8'hF7, {k[1:0], 3'b100, 3'(k * 3)});
  endtask

  task automatic t_idle_r10();
    logic [1:0] sz;
    logic [3:0] src;
    send("R10 setup", 1, 0, 0, 1, 0, 8'hF7, 8'h65);
    sz = out_size; src = {out_src_mem, out_src_rm};
    opcode = 8'hF6; modrm = 8'hE7; pfx_opsz = 1'b0;
    @(negedge clk);
    check("R10 idle valid", int'(out_valid), 0);
    check("R10 idle fault", int'(out_fault), 0);
    check("R10 size held", int'(out_size), int'(sz));
    check("R10 src held", int'({out_src_mem, out_src_rm}), int'(src));
  endtask

  task automatic t_stream_r11();
    for (int k = 0; k < 64; k++)
      send("R11 stream", k[0], k[1], k[2], k[3], k[4] & k[5],
           k[5] ? 8'hF7 : 8'hF6, {k[2:1], 3'b100, k[5:3]});
    check("R11 exclusive", int'(out_valid & out_fault), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset_r1();
    t_byte_r2();
    t_wide64_r3();
    t_ovr16_r4();
    t_dflt32_r5();
    t_rex_legacy_r6();
    t_lock_r7();
    t_other_r8();
    t_src_r9();
    t_idle_r10();
    t_stream_r11();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule